// File: doc/BRIEF.md
# DRAM Refresh Arbiter with Processor Wait

This block sits between a processor and a bank of dynamic memories and decides, cycle by cycle, whether the memory serves a processor access or a row refresh. A slow refresh clock is watched through a synchronizer. Each of its rising edges latches a refresh request, and that request stays pending until a refresh is actually run. The system can grant the request in three ways. In forced mode the next free slot runs it. In hold mode the block raises a bus-request output and waits for an active-low acknowledge. In either mode, a request that finds the refresh clock still high, with the processor quiet, is run at once as a hidden refresh.

During a refresh every RAS line is driven low together, and the address bus carries an internal row counter. That counter advances once per refresh and wraps after the last row. A processor access drives low only the RAS line of its selected bank and passes the processor's address through. The processor is held with WAIT until its own access has completed. The block counts both the minimum RAS low time and the minimum RAS precharge time in generator-clock cycles. Because of this, a refresh that is followed at once by an access can never shorten either interval.

Top module: `dram_rfsh_arb`

## Requirements
- R1: After reset all RAS outputs are high, `wait_o`, `hold_req_o`, `acc_done_o` and `ovf_o` are low, and the first refresh after reset drives row 0 on the address bus.
- R2: A rising edge on `rfclk_i` latches a refresh request that stays pending until a refresh starts; in hold mode (`hold_mode_i`=1) the pending request is visible as `hold_req_o`=1.
- R3: In hold mode, and without a hidden-refresh opportunity, a pending refresh starts only while `hold_ack_n_i` is 0. Processor accesses are still served while it waits. `hold_req_o` falls in the same cycle in which all RAS outputs fall.
- R4: In forced mode (`hold_mode_i`=0) a pending refresh starts at the next free slot and wins over a processor request that is present in the same cycle.
- R5: In hold mode, with no acknowledge and no processor request, a pending refresh starts without acknowledge when the synchronized refresh clock has been high for two samples (hidden refresh).
- R6: A refresh drives every RAS output low (all bits 0) for exactly T_RAS cycles (default 4). After any RAS-low interval all RAS outputs stay high for exactly T_RP cycles (default 2) before the next access or refresh begins.
- R7: During a refresh `addr_o` equals the row counter, zero-extended. The counter advances by one after each refresh and wraps from ROWS-1 (default 127) to 0.
- R8: From an idle slot with `cpu_req_i`=1, only bit `cpu_bank_i` of `ras_n_o` goes low, for exactly T_RAS cycles, with `addr_o`=`cpu_addr_i`. `acc_done_o` pulses for one cycle on the last low cycle.
- R9: `wait_o` is 1 whenever `cpu_req_i` is 1, except in the cycle in which `acc_done_o` is 1. This includes every cycle of a refresh and of its following precharge.
- R10: A rising edge of `rfclk_i` that arrives while a request is still pending sets `ovf_o`. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfclk_i | input | 1 | Slow refresh clock, asynchronous to `clk` |
| hold_mode_i | input | 1 | 1: refresh waits for acknowledge; 0: forced refresh |
| hold_ack_n_i | input | 1 | Active-low grant of the hold request |
| cpu_req_i | input | 1 | Processor access request, held until `acc_done_o` |
| cpu_bank_i | input | $clog2(NBANK) | Bank selected by the processor access |
| cpu_addr_i | input | AW | Processor address passed to the memory during an access |
| ras_n_o | output | NBANK | Active-low row strobes, one per bank |
| addr_o | output | AW | Memory address bus |
| wait_o | output | 1 | Stretches the processor cycle |
| acc_done_o | output | 1 | One-cycle pulse on the last RAS-low cycle of an access |
| hold_req_o | output | 1 | Bus request raised by a pending refresh in hold mode |
| ovf_o | output | 1 | Sticky flag: a refresh period was missed |

## Verification
A corrupted sequencer counter shows up on the next RAS-low or precharge interval. That interval comes out one or more cycles too long or too short, and the bench measures every such interval by counting samples. A wrong row counter shows up on the address bus in the first refresh that follows, because the bench keeps its own row count across every refresh. A lost or duplicated refresh request shows up within a few cycles, through `hold_req_o`, `ovf_o`, or a refresh that begins when it should not.

// File: rtl/dram_rf_pkg.sv
package dram_rf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_RFSH = 2'd2,
        ST_PRE  = 2'd3
    } seq_st_e;

endpackage

// File: rtl/rfr_req_sync.sv
module rfr_req_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rfclk_i,
    input  logic clr_i,
    output logic pend_o,
    output logic lvl_o,
    output logic ovf_o
);

    typedef struct packed {
        logic [2:0] sh;
        logic       pend;
        logic       ovf;
    } req_st_t;

    req_st_t r_q, r_d;
    logic    rise;

    always_comb begin
        r_d      = r_q;
        r_d.sh   = {r_q.sh[1:0], rfclk_i};
        rise     = r_q.sh[1] & ~r_q.sh[2];
        r_d.pend = rise | (r_q.pend & ~clr_i);
        if (rise && r_q.pend && !clr_i) begin
            r_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend_o = r_q.pend;
    assign lvl_o  = r_q.sh[1] & r_q.sh[2];
    assign ovf_o  = r_q.ovf;

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o) else $error("pending request lost"); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o) else $error("overflow flag cleared"); // R10

endmodule

// File: rtl/rfr_row_ctr.sv
module rfr_row_ctr #(
    parameter int ROWS = 128,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    output logic [RW-1:0] row_o
);

    logic [RW-1:0] row_q, row_d;

    always_comb begin
        row_d = row_q;
        if (inc_i) begin
            row_d = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign row_o = row_q;

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && row_o != RW'(ROWS - 1)) |=> row_o == $past(row_o) + 1'b1) else $error("row step"); // R7

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && row_o == RW'(ROWS - 1)) |=> row_o == '0) else $error("row wrap"); // R7

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(row_o)) else $error("row moved"); // R7

endmodule

// File: rtl/rfr_seq.sv
module rfr_seq
    import dram_rf_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int T_RAS = 4,
    parameter int T_RP  = 2,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int TMAX = (T_RAS > T_RP) ? T_RAS : T_RP,
    localparam int CW   = $clog2(TMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rf_go_i,
    input  logic             cpu_req_i,
    input  logic [BW-1:0]    bank_i,
    output logic [NBANK-1:0] ras_n_o,
    output logic             rf_start_o,
    output logic             rf_end_o,
    output logic             acc_done_o,
    output logic             in_rfsh_o
);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bank;
    } seq_t;

    seq_t q, d;
    logic last_low, last_pre, launch;

    always_comb begin
        d          = q;
        rf_start_o = 1'b0;
        rf_end_o   = 1'b0;
        last_low   = (q.cnt == CW'(T_RAS - 1));
        last_pre   = (q.cnt == CW'(T_RP - 1));
        launch     = (q.st == ST_IDLE) || ((q.st == ST_PRE) && last_pre);

        unique case (q.st)
            ST_ACC, ST_RFSH: begin
                if (last_low) begin
                    d.st     = ST_PRE;
                    d.cnt    = '0;
                    rf_end_o = (q.st == ST_RFSH);
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_PRE: begin
                if (last_pre) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.cnt = '0;
            end
        endcase

        if (launch) begin
            if (rf_go_i) begin
                d.st       = ST_RFSH;
                d.cnt      = '0;
                rf_start_o = 1'b1;
            end else if (cpu_req_i) begin
                d.st   = ST_ACC;
                d.cnt  = '0;
                d.bank = bank_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, bank: '0};
        end else begin
            q <= d;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_ras
        assign ras_n_o[b] = !((q.st == ST_RFSH) ||
                              ((q.st == ST_ACC) && (q.bank == BW'(b))));
    end

    assign acc_done_o = (q.st == ST_ACC) && (q.cnt == CW'(T_RAS - 1));
    assign in_rfsh_o  = (q.st == ST_RFSH);

    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PRE && q.cnt == '0) |-> ($past(q.cnt) == CW'(T_RAS - 1))) else $error("RAS low short"); // R6

    AST_PRECH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_PRE && q.st != ST_PRE) |-> ($past(q.cnt) == CW'(T_RP - 1))) else $error("precharge short"); // R6

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACC) |-> ($countones(~ras_n_o) == 1)) else $error("bank strobe"); // R8

    AST_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rf_start_o |=> (ras_n_o == '0)) else $error("refresh strobes"); // R6

endmodule

// File: rtl/dram_rfsh_arb.sv
module dram_rfsh_arb #(
    parameter int NBANK = 4,
    parameter int AW    = 10,
    parameter int ROWS  = 128,
    parameter int T_RAS = 4,
    parameter int T_RP  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rfclk_i,
    input  logic                              hold_mode_i,
    input  logic                              hold_ack_n_i,
    input  logic                              cpu_req_i,
    input  logic [((NBANK > 1) ? $clog2(NBANK) : 1)-1:0] cpu_bank_i,
    input  logic [AW-1:0]                     cpu_addr_i,
    output logic [NBANK-1:0]                  ras_n_o,
    output logic [AW-1:0]                     addr_o,
    output logic                              wait_o,
    output logic                              acc_done_o,
    output logic                              hold_req_o,
    output logic                              ovf_o
);

    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic          pend, lvl, rf_go, rf_start, rf_end, in_rfsh;
    logic [RW-1:0] row;

    rfr_req_sync u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .rfclk_i (rfclk_i),
        .clr_i   (rf_start),
        .pend_o  (pend),
        .lvl_o   (lvl),
        .ovf_o   (ovf_o)
    );

    rfr_row_ctr #(.ROWS(ROWS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (rf_end),
        .row_o (row)
    );

    rfr_seq #(.NBANK(NBANK), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rf_go_i    (rf_go),
        .cpu_req_i  (cpu_req_i),
        .bank_i     (cpu_bank_i),
        .ras_n_o    (ras_n_o),
        .rf_start_o (rf_start),
        .rf_end_o   (rf_end),
        .acc_done_o (acc_done_o),
        .in_rfsh_o  (in_rfsh)
    );

    always_comb begin
        rf_go      = pend & (~hold_mode_i | ~hold_ack_n_i | (lvl & ~cpu_req_i));
        hold_req_o = pend & hold_mode_i;
        wait_o     = cpu_req_i & ~acc_done_o;
        addr_o     = in_rfsh ? AW'(row) : cpu_addr_i;
    end

    AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> (ras_n_o == '0)) else $error("hold ended without refresh"); // R3

    AST_WAIT_RFSH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rfsh && cpu_req_i) |-> wait_o) else $error("no wait in refresh"); // R9

    AST_NO_RF_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode_i && hold_ack_n_i && !lvl && ras_n_o != '0) |=> !($fell(pend) && !$past(pend && !hold_mode_i))) else $error("ungranted refresh"); // R3

endmodule

// File: tb/tb_dram_rfsh_arb.sv
module tb_dram_rfsh_arb;

    localparam int NBANK = 4;
    localparam int AW    = 10;
    localparam int ROWS  = 128;
    localparam int T_RAS = 4;
    localparam int T_RP  = 2;
    localparam int BW    = $clog2(NBANK);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rfclk = 1'b0;
    logic             hold_mode = 1'b0;
    logic             ack_n = 1'b1;
    logic             cpu_req = 1'b0;
    logic [BW-1:0]    cpu_bank = '0;
    logic [AW-1:0]    cpu_addr = '0;
    logic [NBANK-1:0] ras_n;
    logic [AW-1:0]    addr;
    logic             wait_s, done, hold_req, ovf;

    int n_chk = 0;
    int n_err = 0;
    int exp_row = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dram_rfsh_arb #(.NBANK(NBANK), .AW(AW), .ROWS(ROWS), .T_RAS(T_RAS), .T_RP(T_RP)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rfclk_i      (rfclk),
        .hold_mode_i  (hold_mode),
        .hold_ack_n_i (ack_n),
        .cpu_req_i    (cpu_req),
        .cpu_bank_i   (cpu_bank),
        .cpu_addr_i   (cpu_addr),
        .ras_n_o      (ras_n),
        .addr_o       (addr),
        .wait_o       (wait_s),
        .acc_done_o   (done),
        .hold_req_o   (hold_req),
        .ovf_o        (ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rf();
        @(negedge clk) rfclk = 1'b1;
        @(negedge clk) rfclk = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_req = 1'b0; rfclk = 1'b0; ack_n = 1'b1; hold_mode = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        exp_row = 0;
        cyc(1);
    endtask

    task automatic wait_rfsh(input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (ras_n == '0) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    // Called on a sample where all strobes are low; measures the refresh.
    task automatic observe_rfsh(input bit chk_wait, input string tag);
        int lowc = 0, badaddr = 0, badwait = 0;
        while (ras_n == '0 && lowc < 50) begin
            if (addr != AW'(exp_row)) badaddr++;
            if (chk_wait && !wait_s) badwait++;
            lowc++;
            @(negedge clk);
        end
        chk(lowc == T_RAS, {"R6 refresh low length ", tag}, lowc, T_RAS);
        chk(badaddr == 0, {"R7 refresh row address ", tag}, badaddr, 0);
        if (chk_wait) chk(badwait == 0, {"R9 wait during refresh ", tag}, badwait, 0);
        exp_row = (exp_row + 1) % ROWS;
    endtask

    task automatic run_access(input int bank, input int a, input string tag);
        int lowc = 0, badpat = 0, badwait = 0, dn = 0;
        logic [NBANK-1:0] pat;
        pat = ~(NBANK'(1) << bank);
        cpu_bank = BW'(bank);
        cpu_addr = AW'(a);
        cpu_req = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ras_n != '1) begin
                lowc++;
                if (ras_n != pat || addr != AW'(a)) badpat++;
            end
            if (done) begin
                dn++;
                if (wait_s) badwait++;
                cpu_req = 1'b0;
                break;
            end else if (!wait_s) begin
                badwait++;
            end
        end
        chk(dn == 1, {"R8 access done pulse ", tag}, dn, 1);
        chk(lowc == T_RAS, {"R8 access low length ", tag}, lowc, T_RAS);
        chk(badpat == 0, {"R8 bank strobe and address ", tag}, badpat, 0);
        chk(badwait == 0, {"R9 wait during access ", tag}, badwait, 0);
        @(negedge clk);
        chk(ras_n == '1 && !done, {"R8 strobe released ", tag}, int'(ras_n), int'({NBANK{1'b1}}));
    endtask

    task automatic t_reset();
        chk(ras_n == '1, "R1 ras high", int'(ras_n), int'({NBANK{1'b1}}));
        chk(!wait_s && !done && !hold_req && !ovf, "R1 flags low",
            int'({wait_s, done, hold_req, ovf}), 0);
    endtask

    task automatic t_forced();
        bit got;
        hold_mode = 1'b0;
        pulse_rf();
        wait_rfsh(10, got);
        chk(got, "R4 forced refresh starts", int'(got), 1);
        if (got) observe_rfsh(1'b0, "forced");
        cyc(4);
    endtask

    task automatic t_hold();
        bit got;
        int drop_ok;
        hold_mode = 1'b1; ack_n = 1'b1;
        pulse_rf();
        cyc(6);
        chk(hold_req == 1'b1, "R2 hold request raised", int'(hold_req), 1);
        cyc(20);
        chk(ras_n == '1 && hold_req, "R3 no refresh before ack", int'(ras_n), int'({NBANK{1'b1}}));
        run_access(1, 10'h2a5, "during hold");
        chk(hold_req == 1'b1, "R2 request still pending", int'(hold_req), 1);
        ack_n = 1'b0;
        drop_ok = 0;
        for (int i = 0; i < 10; i++) begin
            logic prev;
            prev = hold_req;
            @(negedge clk);
            if (ras_n == '0) begin
                drop_ok = (prev == 1'b1 && hold_req == 1'b0) ? 1 : 2;
                break;
            end
        end
        chk(drop_ok == 1, "R3 hold drops with RAS", drop_ok, 1);
        if (drop_ok != 0) observe_rfsh(1'b0, "hold");
        ack_n = 1'b1;
        cyc(4);
    endtask

    task automatic t_priority_wait();
        int gap = 0, badwait = 0;
        hold_mode = 1'b1; ack_n = 1'b1;
        pulse_rf();
        cyc(5);
        chk(hold_req == 1'b1, "R2 pending before switch", int'(hold_req), 1);
        hold_mode = 1'b0;
        cpu_req = 1'b1; cpu_bank = 2'd3; cpu_addr = 10'h0f3;
        @(negedge clk);
        chk(ras_n == '0, "R4 refresh beats access", int'(ras_n), 0);
        observe_rfsh(1'b1, "before access");
        while (ras_n == '1 && gap < 10) begin
            if (!wait_s) badwait++;
            gap++;
            @(negedge clk);
        end
        chk(gap == T_RP, "R6 precharge before access", gap, T_RP);
        chk(badwait == 0, "R9 wait during precharge", badwait, 0);
        chk(ras_n == 4'b0111 && addr == 10'h0f3, "R8 access after refresh", int'(ras_n), 7);
        for (int i = 0; i < 10; i++) begin
            if (done) begin
                cpu_req = 1'b0;
                break;
            end
            @(negedge clk);
        end
        chk(cpu_req == 1'b0, "R9 access completed", int'(cpu_req), 0);
        cyc(4);
    endtask

    task automatic t_hidden();
        bit got;
        hold_mode = 1'b1; ack_n = 1'b1; cpu_req = 1'b0;
        @(negedge clk) rfclk = 1'b1;
        wait_rfsh(12, got);
        chk(got, "R5 hidden refresh without ack", int'(got), 1);
        if (got) observe_rfsh(1'b0, "hidden");
        cyc(10);
        chk(ras_n == '1 && !hold_req, "R5 single hidden refresh", int'(ras_n), int'({NBANK{1'b1}}));
        rfclk = 1'b0;
        cyc(4);
    endtask

    task automatic t_overflow();
        bit got;
        hold_mode = 1'b1; ack_n = 1'b1;
        pulse_rf();
        cyc(4);
        chk(ovf == 1'b0, "R10 one pending is no overflow", int'(ovf), 0);
        pulse_rf();
        cyc(5);
        chk(ovf == 1'b1, "R10 overflow set", int'(ovf), 1);
        ack_n = 1'b0;
        wait_rfsh(10, got);
        chk(got, "R3 refresh after ack", int'(got), 1);
        if (got) observe_rfsh(1'b0, "overflow");
        ack_n = 1'b1;
        cyc(5);
        chk(ovf == 1'b1 && !hold_req, "R10 overflow sticky", int'(ovf), 1);
    endtask

    task automatic t_wrap();
        bit got;
        int fails = 0;
        int n = ROWS - exp_row + 1;
        hold_mode = 1'b0;
        for (int i = 0; i < n; i++) begin
            pulse_rf();
            wait_rfsh(10, got);
            if (!got) fails++;
            else observe_rfsh(1'b0, "wrap");
            cyc(2);
        end
        chk(fails == 0, "R7 refreshes across wrap", fails, 0);
        chk(exp_row == 1, "R7 wrapped to row 1 next", exp_row, 1);
    endtask

    task automatic t_reset_again();
        bit got;
        do_reset();
        chk(ovf == 1'b0 && ras_n == '1, "R1 reset clears overflow", int'(ovf), 0);
        hold_mode = 1'b0;
        pulse_rf();
        wait_rfsh(10, got);
        if (got) observe_rfsh(1'b0, "row zero after reset");
        chk(got, "R1 first refresh row 0", int'(got), 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        run_access(2, 10'h155, "idle");
        t_forced();
        t_hold();
        t_priority_wait();
        t_hidden();
        t_overflow();
        t_wrap();
        t_reset_again();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule